// File: doc/BRIEF.md
# H-Bridge Command Decoder with Fault Supervisor

This block is the digital control core of a two-leg H-bridge motor driver. Two asynchronous control pins are brought into the clock domain and decoded into four gate enables, one high-side and one low-side per leg. Between them sit a per-leg interlock with programmable dead time and a fault supervisor. The supervisor reads digital fault indications from the analog sensing front end. It shuts the bridge down when a fault is present and drives an open-drain style error flag.

The fault inputs are handled in three ways. Short-circuit and overcurrent indications must persist for a programmable number of clock cycles before they trip a global shutdown. Overtemperature trips the shutdown at once. Undervoltage forces the bridge off only while it lasts and does not set the error flag. When both control pins are high, all transistors are off and the open-load comparators are watched. A tripped error latch is cleared only by a change of the synchronised control pair, never by a dedicated pin.

Top module: `hb_supervisor`

## Requirements
- R1: After reset all four gate enables are 0 and `err_n` is 1 (released).
- R2: Command `{ctl_a,ctl_b}` decodes as: 00 gives leg 0 high-side plus leg 1 low-side; 01 gives leg 0 low-side plus leg 1 high-side; 10 (brake) gives both low-sides; 11 turns all four off. Gate vectors are indexed by leg: bit 0 is leg 0, bit 1 is leg 1.
- R3: When no leg has to hand over from one transistor to the other, a pin change shows at the gates on the third rising clock edge after it.
- R4: A leg never has both enables high. A leg that hands over turns off on the third edge and turns the other side on DEAD_CYC+1 edges later.
- R5: `flt_hs_short` or `flt_ls_ovc` held high on QUAL_CYC consecutive edges drives all gates to 0 and `err_n` to 0 after the QUAL_CYC-th edge, and not after QUAL_CYC-1 edges.
- R6: If the qualified fault drops for at least one edge before the delay runs out, its count restarts from zero.
- R7: `flt_otemp` forces all gates to 0 in the same cycle and sets the error latch on the next edge, without qualification.
- R8: While `flt_uv` is high all gates are 0 and `err_n` stays 1. After it drops, the gates return on the next edge.
- R9: With command 11, `ol_q1_high` and `ol_q2_low` both high for QUAL_CYC edges set the error latch. A single comparator does not set it, and neither does any other command.
- R10: The error latch holds, with the gates off, until the synchronised command changes. The latch then clears on the third edge after the pin change, and the gates follow one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_a | input | 1 | Control pin, command MSB (asynchronous) |
| ctl_b | input | 1 | Control pin, command LSB (asynchronous) |
| flt_hs_short | input | 1 | High-side output shorted to ground |
| flt_ls_ovc | input | 1 | Low-side overcurrent or output shorted to supply |
| flt_otemp | input | 1 | Overtemperature |
| flt_uv | input | 1 | Supply undervoltage |
| ol_q1_high | input | 1 | Open-load comparator: output 1 at supply level |
| ol_q2_low | input | 1 | Open-load comparator: output 2 at ground |
| gate_hs | output | 2 | High-side enable per leg |
| gate_ls | output | 2 | Low-side enable per leg |
| err_n | output | 1 | Error flag: 0 pulls the line low, 1 releases it |

## Verification
The bench builds the block with QUAL_CYC=5 and DEAD_CYC=3 in place of the microsecond-scale defaults. With these values the edges on both sides of the trip point and of each dead-time gap can be checked one by one. They also make a full sweep of all sixteen command-to-command transitions affordable, checked edge by edge against a timeline worked out in the bench. The small qualification window also lets the bench interrupt and restart a fault, and probe a single open-load comparator, within a few dozen cycles.

// File: rtl/hb_pkg.sv
package hb_pkg;

   typedef enum logic [1:0] {
      CMD_CCW   = 2'b00,
      CMD_CW    = 2'b01,
      CMD_BRAKE = 2'b10,
      CMD_FLOAT = 2'b11
   } hb_cmd_e;

   typedef struct packed {
      logic [1:0] hs;
      logic [1:0] ls;
   } hb_gate_t;

   function automatic hb_gate_t hb_decode(input logic [1:0] cmd);
      hb_gate_t g;
      case (cmd)
         CMD_CCW:   begin g.hs = 2'b01; g.ls = 2'b10; end
         CMD_CW:    begin g.hs = 2'b10; g.ls = 2'b01; end
         CMD_BRAKE: begin g.hs = 2'b00; g.ls = 2'b11; end
         default:   begin g.hs = 2'b00; g.ls = 2'b00; end
      endcase
      return g;
   endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
   parameter int          W       = 2,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hb_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/hb_leg.sv
module hb_leg #(
   parameter int DEAD_CYC = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_hs,
   input  logic req_ls,
   output logic hs_q,
   output logic ls_q
);
   localparam int DW = $clog2(DEAD_CYC + 1);

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("hb_leg: DEAD_CYC must be at least 1");
   end

   logic [DW-1:0] dcnt;
   logic          drop;

   // a transistor that is on but no longer requested must go off first
   assign drop = (hs_q & ~req_hs) | (ls_q & ~req_ls);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q <= 1'b0;
         ls_q <= 1'b0;
         dcnt <= '0;
      end else if (drop) begin
         hs_q <= hs_q & req_hs;
         ls_q <= ls_q & req_ls;
         dcnt <= DW'(DEAD_CYC);
      end else if (dcnt != '0) begin
         dcnt <= dcnt - 1'b1;
      end else begin
         hs_q <= req_hs & ~req_ls;
         ls_q <= req_ls & ~req_hs;
      end
   end

   p_no_shoot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_q && ls_q));
   p_hs_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_q) |-> !$past(ls_q));
   p_ls_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_q) |-> !$past(hs_q));
endmodule

// File: rtl/hb_fault_qual.sv
module hb_fault_qual #(
   parameter int QUAL_CYC = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic qual_fault,
   input  logic instant_fault,
   input  logic clear,
   output logic err_q
);
   localparam int QW = $clog2(QUAL_CYC + 1);

   if (QUAL_CYC < 2) begin : g_bad_qual
      $error("hb_fault_qual: QUAL_CYC must be at least 2");
   end

   logic [QW-1:0] cnt;
   logic          trip;

   assign trip = !clear && qual_fault && (cnt == QW'(QUAL_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear || !qual_fault || trip) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (instant_fault || trip) begin
         err_q <= 1'b1;
      end else if (clear) begin
         err_q <= 1'b0;
      end
   end

   p_otemp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      instant_fault |=> err_q);
   p_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> ($past(instant_fault) || $past(cnt) == QW'(QUAL_CYC - 1)));
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !qual_fault |=> (cnt == '0));
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !clear) |=> err_q);
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !instant_fault) |=> !err_q);
endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor #(
   parameter int QUAL_CYC    = 4000,
   parameter int DEAD_CYC    = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_a,
   input  logic       ctl_b,
   input  logic       flt_hs_short,
   input  logic       flt_ls_ovc,
   input  logic       flt_otemp,
   input  logic       flt_uv,
   input  logic       ol_q1_high,
   input  logic       ol_q2_low,
   output logic [1:0] gate_hs,
   output logic [1:0] gate_ls,
   output logic       err_n
);
   import hb_pkg::*;

   localparam int NLEG = 2;

   logic [1:0] cmd;
   logic [1:0] cmd_q;
   logic       cmd_change;
   logic       err_q;
   logic       kill;
   logic       ol_fault;
   logic       qual_fault;
   hb_gate_t   dec;
   logic [NLEG-1:0] leg_hs;
   logic [NLEG-1:0] leg_ls;

   hb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ctl_a, ctl_b}),
      .q    (cmd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q <= 2'b11;
      else        cmd_q <= cmd;
   end

   assign cmd_change = (cmd != cmd_q);
   assign dec        = hb_decode(cmd);
   assign ol_fault   = (cmd == CMD_FLOAT) && ol_q1_high && ol_q2_low;
   assign qual_fault = flt_hs_short || flt_ls_ovc || ol_fault;
   assign kill       = err_q || flt_uv || flt_otemp;

   hb_fault_qual #(.QUAL_CYC(QUAL_CYC)) i_qual (
      .clk          (clk),
      .rst_n        (rst_n),
      .qual_fault   (qual_fault),
      .instant_fault(flt_otemp),
      .clear        (cmd_change),
      .err_q        (err_q)
   );

   for (genvar g = 0; g < NLEG; g++) begin : g_leg
      hb_leg #(.DEAD_CYC(DEAD_CYC)) i_leg (
         .clk   (clk),
         .rst_n (rst_n),
         .req_hs(dec.hs[g] & ~kill),
         .req_ls(dec.ls[g] & ~kill),
         .hs_q  (leg_hs[g]),
         .ls_q  (leg_ls[g])
      );
   end

   // immediate cut for overtemperature and undervoltage, latch holds it off
   assign gate_hs = leg_hs & {NLEG{~kill}};
   assign gate_ls = leg_ls & {NLEG{~kill}};
   assign err_n   = ~err_q;

   p_uv_noerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_uv && !flt_otemp && !qual_fault && !err_q) |=> !err_q);
   p_ol_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_FLOAT && !flt_hs_short && !flt_ls_ovc && !flt_otemp && !err_q)
      |=> !err_q);
endmodule

// File: tb/test_hb_supervisor.sv
module test_hb_supervisor;
   localparam int QUAL = 5;
   localparam int DEAD = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_a = 1'b1, ctl_b = 1'b1;
   logic flt_hs_short = 0, flt_ls_ovc = 0, flt_otemp = 0, flt_uv = 0;
   logic ol_q1_high = 0, ol_q2_low = 0;
   logic [1:0] gate_hs, gate_ls;
   logic err_n;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   hb_supervisor #(.QUAL_CYC(QUAL), .DEAD_CYC(DEAD)) i_hb_supervisor (
      .clk(clk), .rst_n(rst_n), .ctl_a(ctl_a), .ctl_b(ctl_b),
      .flt_hs_short(flt_hs_short), .flt_ls_ovc(flt_ls_ovc),
      .flt_otemp(flt_otemp), .flt_uv(flt_uv),
      .ol_q1_high(ol_q1_high), .ol_q2_low(ol_q2_low),
      .gate_hs(gate_hs), .gate_ls(gate_ls), .err_n(err_n)
   );

   // {hs[1],hs[0],ls[1],ls[0]}
   function automatic logic [3:0] exp_g(input logic [1:0] c);
      case (c)
         2'b00:   return 4'b01_10;
         2'b01:   return 4'b10_01;
         2'b10:   return 4'b00_11;
         default: return 4'b00_00;
      endcase
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic [1:0] c);
      ctl_a = c[1];
      ctl_b = c[0];
   endtask

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   function automatic logic [3:0] gates();
      return {gate_hs, gate_ls};
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R1 gates", gates(), 4'b0000);
      chk("R1 err_n", {3'b0, err_n}, 4'b0001);

      // R5: qualified high-side short
      drive(2'b00); step(10);
      chk("R2 ccw", gates(), exp_g(2'b00));
      flt_hs_short = 1; step(QUAL - 1);
      chk("R5 no early trip", {3'b0, err_n}, 4'b0001);
      chk("R5 gates before trip", gates(), exp_g(2'b00));
      step(1);
      chk("R5 trip err_n", {3'b0, err_n}, 4'b0000);
      chk("R5 trip gates", gates(), 4'b0000);
      flt_hs_short = 0; step(20);
      chk("R10 latch held", {3'b0, err_n}, 4'b0000);
      chk("R10 gates held off", gates(), 4'b0000);
      drive(2'b01); step(2);
      chk("R10 not yet cleared", {3'b0, err_n}, 4'b0000);
      step(1);
      chk("R10 cleared", {3'b0, err_n}, 4'b0001);
      step(1);
      chk("R10 gates return", gates(), exp_g(2'b01));

      // R6: restart of qualification
      step(10);
      flt_ls_ovc = 1; step(QUAL - 1);
      flt_ls_ovc = 0; step(1);
      flt_ls_ovc = 1; step(QUAL - 1);
      chk("R6 restart no trip", {3'b0, err_n}, 4'b0001);
      step(1);
      chk("R6 trip after full window", {3'b0, err_n}, 4'b0000);
      flt_ls_ovc = 0;
      drive(2'b10); step(3);
      chk("R10 clear after ovc", {3'b0, err_n}, 4'b0001);
      step(10);
      chk("R2 brake", gates(), exp_g(2'b10));

      // R7: overtemperature
      flt_otemp = 1; #1;
      chk("R7 immediate gate cut", gates(), 4'b0000);
      @(negedge clk);
      chk("R7 err next edge", {3'b0, err_n}, 4'b0000);
      flt_otemp = 0; step(5);
      chk("R7 latch held", {3'b0, err_n}, 4'b0000);
      drive(2'b11); step(3);
      chk("R10 clear after otemp", {3'b0, err_n}, 4'b0001);

      // R9: open load
      step(10);
      ol_q1_high = 1; step(2 * QUAL);
      chk("R9 single comparator", {3'b0, err_n}, 4'b0001);
      ol_q2_low = 1; step(QUAL - 1);
      chk("R9 no early trip", {3'b0, err_n}, 4'b0001);
      step(1);
      chk("R9 open load trip", {3'b0, err_n}, 4'b0000);
      ol_q1_high = 0; ol_q2_low = 0;
      drive(2'b00); step(3);
      chk("R10 clear after open load", {3'b0, err_n}, 4'b0001);
      step(10);
      ol_q1_high = 1; ol_q2_low = 1; step(2 * QUAL);
      chk("R9 ignored outside 11", {3'b0, err_n}, 4'b0001);
      chk("R9 gates kept outside 11", gates(), exp_g(2'b00));
      ol_q1_high = 0; ol_q2_low = 0;

      // R8: undervoltage
      drive(2'b01); step(12);
      flt_uv = 1; #1;
      chk("R8 immediate cut", gates(), 4'b0000);
      step(20);
      chk("R8 gates held off", gates(), 4'b0000);
      chk("R8 no error", {3'b0, err_n}, 4'b0001);
      flt_uv = 0; step(1);
      chk("R8 gates return", gates(), exp_g(2'b01));

      // R2 R3 R4: sweep of all command transitions
      for (int f = 0; f < 4; f++) begin
         for (int t = 0; t < 4; t++) begin
            logic [3:0] eo, en;
            drive(2'(f)); step(12);
            eo = exp_g(2'(f));
            en = exp_g(2'(t));
            drive(2'(t));
            for (int k = 1; k <= 3 + DEAD + 2; k++) begin
               logic [3:0] e;
               step(1);
               for (int l = 0; l < 2; l++) begin
                  logic oh, ol, nh, nl, conf, eh, el;
                  oh = eo[2 + l]; ol = eo[l];
                  nh = en[2 + l]; nl = en[l];
                  conf = (oh & ~nh) | (ol & ~nl);
                  if (k < 3) begin eh = oh; el = ol; end
                  else if (conf && k < 3 + DEAD + 1) begin eh = 0; el = 0; end
                  else begin eh = nh; el = nl; end
                  e[2 + l] = eh; e[l] = el;
               end
               chk($sformatf("R4 R3 R2 %0d->%0d edge %0d", f, t, k), gates(), e);
            end
         end
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule